// File: doc/BRIEF.md
# Watermark FIFO Mailbox Channel

This block is a one-way word channel between two agents on a chip. A writer pushes 32-bit words into a 32-entry FIFO through a push port register, and a reader pops them in the same order through a pop port register. Both agents reach the block through one simple register bus. Each bus access is a single-cycle request. Read data is combinational from the addressed register.

A programmable watermark compares the occupancy with a threshold. A status register reports the watermark, full and empty conditions, together with two sticky error flags for a push into a full FIFO and a pop from an empty one. Seven interrupt sources latch on transitions of these conditions. The sources are full, empty, not-empty, watermark crossed upwards, watermark crossed downwards, overflow and underflow. They clear by writing ones to a clear register. Each side has its own enable mask. The writer typically enables the empty source to learn that the reader has drained a message. The reader enables the upward watermark crossing or the not-empty source to learn that data has arrived.

Top module: `mbox_fifo_chan`

## Requirements
- R1: After reset, the status register (0xB4) reads 0x04 (empty only), the watermark register (0xB8) reads 32, the interrupt status register (0xC8) reads 0, and both interrupt outputs are low.
- R2: Words written to the push port (0xAC) are returned by reads of the pop port (0xB0) in the order written, and each read removes one word.
- R3: With 32 words stored, status bit 1 (full) is set. A further push drops its word and sets status bit 4 (overflow). The overflow bit stays set until the FIFO is reset.
- R4: A read of the pop port while the FIFO is empty returns 0 and sets status bit 3 (underflow). The underflow bit stays set until the FIFO is reset.
- R5: Status bit 0 is set exactly when the occupancy is greater than or equal to the watermark register value. Status bit 2 is set when the occupancy is zero.
- R6: Interrupt status bit 4 latches when the watermark flag goes from 0 to 1. Interrupt status bit 5 latches when the flag goes from 1 to 0.
- R7: Interrupt status bits 2 (full), 3 (empty) and 8 (not-empty) latch on the rising edge of their condition. Writing a 1 to the matching bit of the clear register (0xC4) clears the latched bit.
- R8: Interrupt status bit 6 latches when the overflow flag sets. Interrupt status bit 7 latches when the underflow flag sets.
- R9: Writing the reset register (0xCC) with bit 0 set empties the FIFO and clears the overflow and underflow flags. Writing the reset register with bit 0 clear has no effect.
- R10: The writer interrupt `irq_wr_o` is high while any latched interrupt bit is also set in the writer enable register (0xBC). The reader interrupt `irq_rd_o` follows the same rule with the reader enable register (0xC0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register |
| irq_wr_o | output | 1 | Writer-side interrupt |
| irq_rd_o | output | 1 | Reader-side interrupt |

## Verification
The FIFO is exercised with three patterns. A short three-word burst shows ordering and the transitions between empty and not-empty. A three-deep watermark run crosses the threshold upwards and then downwards, and so separates the two crossing sources from the level flag. A fill to capacity followed by an extra push shows that the dropped word never appears when the FIFO is drained, and that overflow outlives the drain. Pops from an empty FIFO and a reset write with bit 0 clear separate sticky errors and ignored writes from real clears. Reading back the enable masks per side shows which interrupt output each source reaches.

// File: rtl/mbox_fifo_pkg.sv
package mbox_fifo_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned NSRC   = 9;

  localparam logic [ADDR_W-1:0] A_PUSH  = 8'hAC;
  localparam logic [ADDR_W-1:0] A_POP   = 8'hB0;
  localparam logic [ADDR_W-1:0] A_STAT  = 8'hB4;
  localparam logic [ADDR_W-1:0] A_WMARK = 8'hB8;
  localparam logic [ADDR_W-1:0] A_EN_WR = 8'hBC;
  localparam logic [ADDR_W-1:0] A_EN_RD = 8'hC0;
  localparam logic [ADDR_W-1:0] A_CLR   = 8'hC4;
  localparam logic [ADDR_W-1:0] A_IST   = 8'hC8;
  localparam logic [ADDR_W-1:0] A_FLUSH = 8'hCC;

  // interrupt source positions
  localparam int unsigned I_FULL  = 2;
  localparam int unsigned I_EMPTY = 3;
  localparam int unsigned I_WMUP  = 4;
  localparam int unsigned I_WMDN  = 5;
  localparam int unsigned I_OFLOW = 6;
  localparam int unsigned I_UFLOW = 7;
  localparam int unsigned I_NEMP  = 8;

  localparam logic [NSRC-1:0] SRC_MASK = 9'h1FC;
endpackage

// File: rtl/mbox_fifo_store.sv
module mbox_fifo_store #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          flush_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/mbox_fifo_irq.sv
module mbox_fifo_irq #(
  parameter int unsigned N = 9,
  parameter logic [N-1:0] RST_PREV = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] cond_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] ist_o
);
  logic [N-1:0] prev_q, ist_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[i] <= RST_PREV[i];
        ist_q[i]  <= 1'b0;
      end else begin
        prev_q[i] <= cond_i[i];
        // a new edge wins over a clear in the same cycle
        if (cond_i[i] && !prev_q[i]) ist_q[i] <= 1'b1;
        else if (clr_i[i])           ist_q[i] <= 1'b0;
      end
    end
  end

  assign ist_o = ist_q;
endmodule

// File: rtl/mbox_fifo_chan.sv
module mbox_fifo_chan
  import mbox_fifo_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_wr_o,
  output logic              irq_rd_o
);
  logic          wr_acc, rd_acc;
  logic          push, pop, flush;
  logic [DW-1:0] head;
  logic [CW-1:0] count;
  logic [CW-1:0] wm_q;
  logic          full, empty, wm_flag;
  logic          oflow_q, uflow_q;
  logic [NSRC-1:0] en_wr_q, en_rd_q, int_stat, cond, clr;

  assign wr_acc = req_i && we_i;
  assign rd_acc = req_i && !we_i;
  assign push   = wr_acc && (addr_i == A_PUSH);
  assign pop    = rd_acc && (addr_i == A_POP);
  assign flush  = wr_acc && (addr_i == A_FLUSH) && wdata_i[0];
  assign clr    = (wr_acc && (addr_i == A_CLR)) ? wdata_i[NSRC-1:0] : '0;

  mbox_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .flush_i (flush),
    .wdata_i (wdata_i),
    .head_o  (head),
    .count_o (count)
  );

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign wm_flag = (count >= wm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wm_q    <= CW'(DEPTH);
      en_wr_q <= '0;
      en_rd_q <= '0;
      oflow_q <= 1'b0;
      uflow_q <= 1'b0;
    end else begin
      if (wr_acc && addr_i == A_WMARK) wm_q    <= wdata_i[CW-1:0];
      if (wr_acc && addr_i == A_EN_WR) en_wr_q <= wdata_i[NSRC-1:0] & SRC_MASK;
      if (wr_acc && addr_i == A_EN_RD) en_rd_q <= wdata_i[NSRC-1:0] & SRC_MASK;
      if (flush) begin
        oflow_q <= 1'b0;
        uflow_q <= 1'b0;
      end else begin
        if (push && full) oflow_q <= 1'b1;
        if (pop && empty) uflow_q <= 1'b1;
      end
    end
  end

  always_comb begin
    cond          = '0;
    cond[I_FULL]  = full;
    cond[I_EMPTY] = empty;
    cond[I_WMUP]  = wm_flag;
    cond[I_WMDN]  = !wm_flag;
    cond[I_OFLOW] = oflow_q;
    cond[I_UFLOW] = uflow_q;
    cond[I_NEMP]  = !empty;
  end

  // previous-level reset values match the reset-time conditions
  localparam logic [NSRC-1:0] PREV0 = (NSRC'(1) << I_EMPTY) | (NSRC'(1) << I_WMDN);

  mbox_fifo_irq #(.N(NSRC), .RST_PREV(PREV0)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (cond),
    .clr_i  (clr),
    .ist_o  (int_stat)
  );

  assign irq_wr_o = |(int_stat & en_wr_q);
  assign irq_rd_o = |(int_stat & en_rd_q);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_POP:   rdata_o = empty ? '0 : head;
      A_STAT:  rdata_o = DW'({oflow_q, uflow_q, empty, full, wm_flag});
      A_WMARK: rdata_o = DW'(wm_q);
      A_EN_WR: rdata_o = DW'(en_wr_q);
      A_EN_RD: rdata_o = DW'(en_rd_q);
      A_IST:   rdata_o = DW'(int_stat);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mbox_fifo_chk.sv
module mbox_fifo_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CW    = 6,
  parameter int unsigned NSRC  = 9
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            push,
  input logic            pop,
  input logic            flush,
  input logic [CW-1:0]   count,
  input logic            full,
  input logic            empty,
  input logic            oflow_q,
  input logic            uflow_q,
  input logic            wm_flag,
  input logic [NSRC-1:0] int_stat
);
  // R3
  always @(posedge clk_i) begin
    if (rst_ni) count_bound_chk: assert (count <= CW'(DEPTH));
  end

  // R3
  drop_on_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push && full && !flush |=> $stable(count) && oflow_q);

  // R3
  oflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oflow_q && !flush |=> oflow_q);

  // R4
  uflow_on_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop && empty && !flush |=> uflow_q && (count == '0));

  // R2
  push_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push && !full && !pop && !flush |=> count == $past(count) + 1'b1);

  // R9
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (count == '0) && !oflow_q && !uflow_q);

  // R6
  wm_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wm_flag) |=> int_stat[4]);

  // R6
  wm_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wm_flag) |=> int_stat[5]);
endmodule

bind mbox_fifo_chan mbox_fifo_chk #(.DEPTH(DEPTH), .CW(CW), .NSRC(mbox_fifo_pkg::NSRC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .push     (push),
  .pop      (pop),
  .flush    (flush),
  .count    (count),
  .full     (full),
  .empty    (empty),
  .oflow_q  (oflow_q),
  .uflow_q  (uflow_q),
  .wm_flag  (wm_flag),
  .int_stat (int_stat)
);

// File: tb/tb_mbox_fifo_chan.sv
module tb_mbox_fifo_chan;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_wr_o, irq_rd_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  mbox_fifo_chan dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_wr_o, .irq_rd_o
  );

  typedef struct packed {
    logic        rd;
    logic [7:0]  addr;
    logic [31:0] data;  // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'hB4, 32'h04,  4'd1},   // R1 status empty
    '{1'b1, 8'hB8, 32'd32,  4'd1},   // R1 watermark default
    '{1'b1, 8'hC8, 32'h0,   4'd1},   // R1 no interrupts
    '{1'b0, 8'hAC, 32'h11,  4'd2},   // R2 push
    '{1'b1, 8'hC8, 32'h100, 4'd7},   // R7 not-empty latched
    '{1'b1, 8'hB4, 32'h00,  4'd5},   // R5 one word, below watermark
    '{1'b0, 8'hAC, 32'h22,  4'd2},
    '{1'b0, 8'hAC, 32'h33,  4'd2},
    '{1'b1, 8'hB0, 32'h11,  4'd2},   // R2 order
    '{1'b1, 8'hB0, 32'h22,  4'd2},
    '{1'b1, 8'hB0, 32'h33,  4'd2},
    '{1'b1, 8'hB4, 32'h04,  4'd5},   // R5 empty again
    '{1'b1, 8'hC8, 32'h108, 4'd7},   // R7 empty latched
    '{1'b0, 8'hC4, 32'h108, 4'd7},
    '{1'b1, 8'hC8, 32'h0,   4'd7},   // R7 cleared
    '{1'b1, 8'hB0, 32'h0,   4'd4},   // R4 empty pop returns 0
    '{1'b1, 8'hB4, 32'h0C,  4'd4},   // R4 underflow set
    '{1'b1, 8'hC8, 32'h80,  4'd8},   // R8 underflow interrupt
    '{1'b1, 8'hB4, 32'h0C,  4'd4},   // R4 sticky
    '{1'b0, 8'hCC, 32'h0,   4'd9},   // R9 bit 0 clear
    '{1'b1, 8'hB4, 32'h0C,  4'd9},   // R9 no effect
    '{1'b0, 8'hCC, 32'h1,   4'd9},
    '{1'b1, 8'hB4, 32'h04,  4'd9},   // R9 flags cleared
    '{1'b0, 8'hC4, 32'h1FF, 4'd7}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #4 d = rdata_o;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string rq);
    logic [31:0] v;
    bus_rd(a, v);
    chk(rq, v, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    #2;
    chk("R1 irq_wr", {31'b0, irq_wr_o}, 32'h0);
    chk("R1 irq_rd", {31'b0, irq_rd_o}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].rd) begin
        bus_rd(TBL[i].addr, v);
        chk($sformatf("R%0d vec %0d", TBL[i].req, i), v, TBL[i].data);
      end else begin
        bus_wr(TBL[i].addr, TBL[i].data);
      end
    end

    // R10 enables per side
    bus_wr(8'hBC, 32'h08);
    bus_wr(8'hC0, 32'h100);
    rd_chk(8'hBC, 32'h08, "R10 writer enable");
    rd_chk(8'hC0, 32'h100, "R10 reader enable");

    // R5 / R6 watermark 3
    bus_wr(8'hB8, 32'd3);
    bus_wr(8'hAC, 32'hA1);
    bus_wr(8'hAC, 32'hA2);
    rd_chk(8'hB4, 32'h00, "R5 below watermark");
    bus_wr(8'hAC, 32'hA3);
    rd_chk(8'hB4, 32'h01, "R5 at watermark");
    rd_chk(8'hC8, 32'h110, "R6 upward crossing");
    chk("R10 irq_rd", {31'b0, irq_rd_o}, 32'h1);
    chk("R10 irq_wr", {31'b0, irq_wr_o}, 32'h0);
    rd_chk(8'hB0, 32'hA1, "R2 pop");
    rd_chk(8'hB4, 32'h00, "R5 below again");
    rd_chk(8'hC8, 32'h130, "R6 downward crossing");
    bus_wr(8'hC4, 32'h1FF);
    chk("R10 irq_rd cleared", {31'b0, irq_rd_o}, 32'h0);
    rd_chk(8'hB0, 32'hA2, "R2 pop");
    rd_chk(8'hB0, 32'hA3, "R2 pop");
    rd_chk(8'hC8, 32'h008, "R7 empty edge");
    chk("R10 irq_wr", {31'b0, irq_wr_o}, 32'h1);
    bus_wr(8'hC4, 32'h008);
    chk("R10 irq_wr cleared", {31'b0, irq_wr_o}, 32'h0);

    // R3 fill, overflow, drain
    bus_wr(8'hB8, 32'd32);
    for (int i = 0; i < 32; i++) bus_wr(8'hAC, 32'h100 + i);
    rd_chk(8'hB4, 32'h03, "R3 full");
    bus_wr(8'hAC, 32'hDEAD);
    rd_chk(8'hB4, 32'h13, "R3 overflow");
    rd_chk(8'hC8, 32'h154, "R8 overflow interrupt");
    for (int i = 0; i < 32; i++) rd_chk(8'hB0, 32'h100 + i, "R3 drain order");
    rd_chk(8'hB4, 32'h14, "R3 overflow sticky");
    bus_wr(8'hCC, 32'h1);
    rd_chk(8'hB4, 32'h04, "R9 flush");

    finish_run();
  end
endmodule